// File: doc/BRIEF.md
# Adjacent-Wire Coupling Transition Counter

This block estimates how much inter-wire coupling energy a bus would spend if a new word replaced the word now on its wires. It looks at every pair of neighbouring wires and compares the pair's old values with its new values. A pair whose wires held the same value and now hold different values is a single-weight event. A pair whose two wires swap values in opposite directions is a double-weight event. All other pair changes cost nothing.

The block is purely combinational. The outputs follow the two input words within the same cycle and hold no state, so there is no clock, no reset and no handshake. A bus encoder places it in front of its inversion decision and compares the weighted total with a threshold. Self-transitions and the encoding choice itself are handled elsewhere. The word width is a parameter of at least 2.

Top module: `adj_coupling_counter`

## Requirements
- R1: For each neighbouring pair (bit i, bit i+1), a single-weight event is counted when the old pair bits were equal (00 or 11) and the new pair bits differ (01 or 10).
- R2: For each neighbouring pair, a double-weight event is counted when the pair goes from 01 to 10 or from 10 to 01.
- R3: Any other pair change (equal to equal, differing to equal, or unchanged differing) adds nothing to either count. For example, a 4-bit word going from 0000 to 1111 gives zero in every output.
- R4: `single_cnt` is the number of single-weight events over all WIDTH-1 pairs, and `double_cnt` is the number of pairs with a double-weight event.
- R5: `weighted_sum` equals `single_cnt` plus twice `double_cnt`.
- R6: With old word 16'b1100001010000111 and new word 16'b1010100100110101, the outputs are `single_cnt`=8, `double_cnt`=3 and `weighted_sum`=14 (double-weight part 6).
- R7: The output widths hold the worst case without wrapping. An alternating word replaced by its complement (for example 0101 to 1010) gives `double_cnt`=WIDTH-1 and `weighted_sum`=2*(WIDTH-1).
- R8: The outputs depend only on the present inputs. New inputs give the correct outputs within the same cycle, with no clock edge in between.
- R9: A pair is never counted as both kinds of event, so `single_cnt` + `double_cnt` never exceeds WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prev_word | input | WIDTH | Word currently driven on the bus wires |
| next_word | input | WIDTH | Newly arrived word to be compared |
| single_cnt | output | clog2(WIDTH) | Number of single-weight pair events |
| double_cnt | output | clog2(WIDTH) | Number of pairs with an opposite flip |
| weighted_sum | output | clog2(2*WIDTH) | single_cnt + 2*double_cnt |

## Verification
The block holds no state. A fault in a pair classifier or in a counter therefore shows at the ports at once, for the input pattern that exercises it, and vanishes when the inputs change. A misclassified pair shifts `single_cnt` or `double_cnt` by one and `weighted_sum` by one or two. A truncated counter shows only near the worst case, so the bench sweeps every input combination at width 4 and drives the alternating worst case at width 16.

// File: rtl/coupling_pkg.sv
package coupling_pkg;

  // Bits needed to count up to w-1 events (one per neighbouring pair).
  function automatic int cnt_bits(input int w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction

  // Bits needed to hold the weighted total, up to 2*(w-1).
  function automatic int sum_bits(input int w);
    return $clog2(2 * w);
  endfunction

  typedef struct packed {
    logic single_ev;
    logic double_ev;
  } pair_event_t;

endpackage

// File: rtl/cpl_pair_classify.sv
module cpl_pair_classify
  import coupling_pkg::*;
(
  input  logic        old_lo,
  input  logic        old_hi,
  input  logic        new_lo,
  input  logic        new_hi,
  output pair_event_t ev
);

  logic old_split;
  logic new_split;
  logic lo_moved;

  always_comb begin
    old_split    = old_lo ^ old_hi;
    new_split    = new_lo ^ new_hi;
    lo_moved     = old_lo ^ new_lo;
    ev.single_ev = ~old_split & new_split;
    ev.double_ev = old_split & new_split & lo_moved;
  end

  // Single event only from an equal old pair to a split new pair (R1).
  always_comb begin
    if (ev.single_ev) begin
      p_single_src_r1: assert (old_lo == old_hi && new_lo != new_hi);
    end
  end

  // Double event only when both wires change, in opposite directions (R2).
  always_comb begin
    if (ev.double_ev) begin
      p_double_src_r2: assert (new_lo != old_lo && new_hi != old_hi && new_lo != new_hi);
    end
  end

  // A pair carries at most one kind of event (R9).
  always_comb begin
    p_excl_r9: assert (!(ev.single_ev && ev.double_ev));
  end

endmodule

// File: rtl/cpl_popcount.sv
module cpl_popcount #(
  parameter int N  = 15,
  parameter int OW = 4
) (
  input  logic [N-1:0]  bits_in,
  output logic [OW-1:0] ones
);

  always_comb begin
    ones = '0;
    for (int k = 0; k < N; k++) begin
      ones = ones + OW'(bits_in[k]);
    end
  end

  // The count fits the width and never exceeds the number of inputs (R4, R7).
  always_comb begin
    p_cnt_range_r4: assert (int'(ones) <= N);
  end

endmodule

// File: rtl/adj_coupling_counter.sv
module adj_coupling_counter
  import coupling_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]                  prev_word,
  input  logic [WIDTH-1:0]                  next_word,
  output logic [cnt_bits(WIDTH)-1:0]        single_cnt,
  output logic [cnt_bits(WIDTH)-1:0]        double_cnt,
  output logic [sum_bits(WIDTH)-1:0]        weighted_sum
);

  localparam int PAIRS = WIDTH - 1;
  localparam int CW    = cnt_bits(WIDTH);
  localparam int SW    = sum_bits(WIDTH);

  pair_event_t      pair_ev [PAIRS];
  logic [PAIRS-1:0] single_vec;
  logic [PAIRS-1:0] double_vec;

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    cpl_pair_classify u_cls (
      .old_lo (prev_word[g]),
      .old_hi (prev_word[g+1]),
      .new_lo (next_word[g]),
      .new_hi (next_word[g+1]),
      .ev     (pair_ev[g])
    );
    assign single_vec[g] = pair_ev[g].single_ev;
    assign double_vec[g] = pair_ev[g].double_ev;
  end

  cpl_popcount #(.N(PAIRS), .OW(CW)) u_single_cnt (
    .bits_in (single_vec),
    .ones    (single_cnt)
  );

  cpl_popcount #(.N(PAIRS), .OW(CW)) u_double_cnt (
    .bits_in (double_vec),
    .ones    (double_cnt)
  );

  always_comb begin
    weighted_sum = SW'(single_cnt) + (SW'(double_cnt) << 1);
  end

  // Both counts together never exceed the pair count (R9).
  always_comb begin
    p_pair_budget_r9: assert (int'(single_cnt) + int'(double_cnt) <= PAIRS);
  end

  // The total stays within the worst case 2*(WIDTH-1) (R7).
  always_comb begin
    p_no_overflow_r7: assert (int'(weighted_sum) <= 2 * PAIRS);
  end

  // An unchanged word produces no coupling events (R3).
  always_comb begin
    if (prev_word == next_word) begin
      p_static_zero_r3: assert (weighted_sum == '0);
    end
  end

endmodule

// File: tb/adj_coupling_counter_tb.sv
module adj_coupling_counter_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // Width 16 instance
  logic [15:0] p16, n16;
  logic [3:0]  s16, d16;
  logic [4:0]  t16;

  adj_coupling_counter #(.WIDTH(16)) u_dut (
    .prev_word    (p16),
    .next_word    (n16),
    .single_cnt   (s16),
    .double_cnt   (d16),
    .weighted_sum (t16)
  );

  // Width 4 instance for exhaustive sweep
  logic [3:0] p4, n4;
  logic [1:0] s4, d4;
  logic [2:0] t4;

  adj_coupling_counter #(.WIDTH(4)) u_dut_small (
    .prev_word    (p4),
    .next_word    (n4),
    .single_cnt   (s4),
    .double_cnt   (d4),
    .weighted_sum (t4)
  );

  task automatic model(input logic [31:0] p, input logic [31:0] n, input int w,
                       output int s, output int d);
    s = 0;
    d = 0;
    for (int i = 0; i < w - 1; i++) begin
      if (p[i] == p[i+1] && n[i] != n[i+1]) s++;
      else if (p[i] != p[i+1] && n[i] != n[i+1] && n[i] != p[i]) d++;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply4(input logic [3:0] p, input logic [3:0] n);
    p4 = p;
    n4 = n;
    #3;
  endtask

  task automatic apply16(input logic [15:0] p, input logic [15:0] n);
    p16 = p;
    n16 = n;
    #3;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int es, ed;
    p4 = '0; n4 = '0; p16 = '0; n16 = '0;
    @(negedge clk);

    // Quiescent inputs give zero outputs (R3)
    #1;
    chk("R3 idle single16", int'(s16), 0);
    chk("R3 idle total16", int'(t16), 0);
    chk("R3 idle total4", int'(t4), 0);

    // R1: 0000 -> 0001, pair0 goes 00 -> split
    apply4(4'b0000, 4'b0001);
    chk("R1 single", int'(s4), 1);
    chk("R1 double", int'(d4), 0);

    // R2: 0001 -> 0010, pair0 01->10 double, pair1 00->01 single
    apply4(4'b0001, 4'b0010);
    chk("R2 double", int'(d4), 1);
    chk("R2 single", int'(s4), 1);
    chk("R5 total", int'(t4), 3);

    // R3: 0000 -> 1111 contributes nothing
    apply4(4'b0000, 4'b1111);
    chk("R3 all-rise single", int'(s4), 0);
    chk("R3 all-rise double", int'(d4), 0);
    // R3: split to equal contributes nothing
    apply4(4'b0101, 4'b0000);
    chk("R3 split-to-equal", int'(t4), 0);

    // R7: worst case at width 4 and 16
    apply4(4'b0101, 4'b1010);
    chk("R7 double4", int'(d4), 3);
    chk("R7 total4", int'(t4), 6);
    apply16(16'h5555, 16'hAAAA);
    chk("R7 double16", int'(d16), 15);
    chk("R7 total16", int'(t16), 30);

    // R6: worked example
    apply16(16'b1100001010000111, 16'b1010100100110101);
    chk("R6 single", int'(s16), 8);
    chk("R6 double", int'(d16), 3);
    chk("R6 total", int'(t16), 14);

    // R8: change inputs between clock edges; outputs follow with no edge
    @(posedge clk);
    #1;
    p16 = 16'h0000;
    n16 = 16'h0001;
    #1;
    chk("R8 same-cycle single", int'(s16), 1);
    n16 = 16'h0002;
    #1;
    chk("R8 same-cycle total", int'(t16), 2);

    // R1 R2 R4 R5 R9: exhaustive sweep at width 4
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply4(4'(a), 4'(b));
        model(32'(a), 32'(b), 4, es, ed);
        chk("R4 sweep single4", int'(s4), es);
        chk("R4 sweep double4", int'(d4), ed);
        chk("R5 sweep total4", int'(t4), es + 2 * ed);
        chk("R9 sweep budget4", (int'(s4) + int'(d4) <= 3) ? 1 : 0, 1);
      end
    end

    // R4 R5 R9: random vectors at width 16
    for (int k = 0; k < 2000; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      apply16(ra, rb);
      model(32'(ra), 32'(rb), 16, es, ed);
      chk("R4 rand single16", int'(s16), es);
      chk("R4 rand double16", int'(d16), ed);
      chk("R5 rand total16", int'(t16), es + 2 * ed);
      chk("R9 rand budget16", (int'(s16) + int'(d16) <= 15) ? 1 : 0, 1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule